// File: doc/BRIEF.md
# Reset and Strap Capture Controller

This block turns an active-low external reset pin and a watchdog reset request into one internal chip reset. While the reset is active it holds the external address bus low and keeps every peripheral clock gated off. When the reset ends it raises a one-cycle pulse that tells the core to fetch from address zero.

While the pin reset is active, the block records two strap pins on every clock. One strap selects the boot memory. The other is an active-low request for tristate mode. When the reset is released, the block latches a boot-mode code and a tristate enable from the most recent sample. It also reports whether the straps held steady across the last ten samples.

A watchdog reset runs the same reset sequence but does not capture the straps. The boot mode and tristate mode chosen at the last pin reset therefore survive it.

Top module: `rst_strap_ctrl`

## Requirements
- R1: A low level on `rst_pin_n` asserts `sys_rst` and `addr_low_hold` and clears `periph_clk_en` at once, without waiting for a clock edge. These three outputs keep those values for as long as `sys_rst` is high.
- R2: When the pin has been low for at least 7 rising edges, `sys_rst` falls at the 3rd rising edge after the pin rises. The pin release passes through a two-flop synchronizer.
- R3: When the pin has been low for fewer than 7 rising edges, `sys_rst` stays high until the 10th rising edge counted from the pin's fall. This gives a full 10-sample strap window.
- R4: Boot mode is latched at pin-reset release. It takes the boot strap sampled at the release edge together with `has_nvm`:
  - strap low gives `2'b00`, external 16-bit memory on chip select 0;
  - strap high with `has_nvm` high gives `2'b10`, internal 32-bit nonvolatile memory;
  - strap high with `has_nvm` low gives `2'b01`, external 8-bit memory on chip select 0.
- R5: `tristate_en` is latched high at pin-reset release when `tri_n_pin` is low at the release edge, and latched low when it is high.
- R6: `strap_unstable` is latched at each pin-reset release. It is 1 when either strap differs anywhere among the 10 samples taken at the last 10 rising edges up to and including the release edge, and 0 otherwise. It holds its value until the next pin-reset release.
- R7: When `wdt_req` is high at a rising edge while the block is running, `sys_rst` is high for exactly 10 clock cycles. `boot_mode`, `tristate_en` and `strap_unstable` keep their values through this reset.
- R8: A pin reset that coincides with, or interrupts, a watchdog reset takes over. The straps are then sampled and latched as in R2 to R6.
- R9: `fetch_zero` is high for exactly the one cycle in which `sys_rst` first reads low after any reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous assert |
| wdt_req | input | 1 | Watchdog reset request, sampled on the clock |
| boot_sel_pin | input | 1 | Boot-memory strap |
| tri_n_pin | input | 1 | Tristate request strap, active low |
| has_nvm | input | 1 | High when on-chip nonvolatile memory is present |
| sys_rst | output | 1 | Internal chip reset, active high |
| addr_low_hold | output | 1 | Forces the external address bus low |
| periph_clk_en | output | 1 | Peripheral clock enable, low during reset |
| fetch_zero | output | 1 | One-cycle pulse at reset release: fetch from address zero |
| boot_mode | output | 2 | Latched boot-mode code (see R4) |
| tristate_en | output | 1 | Latched tristate mode enable |
| strap_unstable | output | 1 | Straps were not steady across the capture window |

## Verification
The bench varies the pin's low time across the point where the 10-sample floor takes over from the synchronizer delay. A design that counted the window from the pin's rise, or skipped the floor, would release one or more cycles early or late.

It also toggles a strap just inside and just outside the window. An off-by-one history would then misreport stability, or latch the stale value.

Watchdog resets are issued with the straps changed. A design that re-sampled on a watchdog reset would change the boot mode.

Pin resets are applied on the same edge as a watchdog request and in the middle of a watchdog reset. A design that let the watchdog counter or phase win would release too early, or keep the old straps.

// File: rtl/rst_strap_pkg.sv
package rst_strap_pkg;

    typedef enum logic [1:0] {
        PH_PIN = 2'd0,
        PH_WDT = 2'd1,
        PH_RUN = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        BOOT_EXT16 = 2'd0,
        BOOT_EXT8  = 2'd1,
        BOOT_INT32 = 2'd2
    } boot_e;

    function automatic boot_e boot_decode(input logic sel, input logic nvm);
        if (!sel)
            return BOOT_EXT16;
        else if (nvm)
            return BOOT_INT32;
        else
            return BOOT_EXT8;
    endfunction

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_pin_n,
    output logic released_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n)
            sync_q <= '0;
        else
            sync_q <= sync_d;
    end

    assign released_o = sync_q[STAGES-1];
endmodule

// File: rtl/strap_history.sv
module strap_history #(
    parameter int DEPTH = 10
) (
    input  logic clk,
    input  logic shift_en,
    input  logic bit_i,
    output logic newest_o,
    output logic agree_o
);
    localparam int KEEP = DEPTH - 1;

    logic [KEEP-1:0]  hist_d, hist_q;
    logic [DEPTH-1:0] window;

    always_comb begin
        window  = {hist_q, bit_i};
        hist_d  = shift_en ? window[KEEP-1:0] : hist_q;
    end

    always_ff @(posedge clk) begin
        hist_q <= hist_d;
    end

    assign newest_o = bit_i;
    assign agree_o  = (&window) | ~(|window);
endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl
    import rst_strap_pkg::*;
#(
    parameter int WINDOW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_pin_n,
    input  logic       wdt_req,
    input  logic       boot_sel_pin,
    input  logic       tri_n_pin,
    input  logic       has_nvm,
    output logic       sys_rst,
    output logic       addr_low_hold,
    output logic       periph_clk_en,
    output logic       fetch_zero,
    output logic [1:0] boot_mode,
    output logic       tristate_en,
    output logic       strap_unstable
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    typedef struct packed {
        phase_e phase;
        logic   fz;
    } ctl_t;

    typedef struct packed {
        logic [CW-1:0] samp;
        logic [CW-1:0] wcnt;
        boot_e         boot;
        logic          trist;
        logic          unstable;
    } dat_t;

    ctl_t ctl_d, ctl_q;
    dat_t dat_d, dat_q;

    logic released;
    logic shift_en;
    logic bs_now, bs_agree, tn_now, tn_agree;

    rst_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_pin_n  (rst_pin_n),
        .released_o (released)
    );

    assign shift_en = (ctl_q.phase == PH_PIN);

    strap_history #(.DEPTH(WINDOW)) u_hist_boot (
        .clk      (clk),
        .shift_en (shift_en),
        .bit_i    (boot_sel_pin),
        .newest_o (bs_now),
        .agree_o  (bs_agree)
    );

    strap_history #(.DEPTH(WINDOW)) u_hist_tri (
        .clk      (clk),
        .shift_en (shift_en),
        .bit_i    (tri_n_pin),
        .newest_o (tn_now),
        .agree_o  (tn_agree)
    );

    always_comb begin
        ctl_d    = ctl_q;
        dat_d    = dat_q;
        ctl_d.fz = 1'b0;
        unique case (ctl_q.phase)
            PH_RUN: begin
                dat_d.samp = '0;
                dat_d.wcnt = '0;
                if (wdt_req)
                    ctl_d.phase = PH_WDT;
            end
            PH_WDT: begin
                dat_d.samp = '0;
                if (dat_q.wcnt >= LAST) begin
                    ctl_d.phase = PH_RUN;
                    ctl_d.fz    = 1'b1;
                    dat_d.wcnt  = '0;
                end else begin
                    dat_d.wcnt = dat_q.wcnt + 1'b1;
                end
            end
            PH_PIN: begin
                dat_d.wcnt = '0;
                dat_d.samp = (dat_q.samp >= LAST) ? LAST : dat_q.samp + 1'b1;
                if (released && dat_q.samp >= LAST) begin
                    ctl_d.phase    = PH_RUN;
                    ctl_d.fz       = 1'b1;
                    dat_d.boot     = boot_decode(bs_now, has_nvm);
                    dat_d.trist    = ~tn_now;
                    dat_d.unstable = ~(bs_agree & tn_agree);
                end
            end
            default: ctl_d.phase = PH_PIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            ctl_q.phase <= PH_PIN;
            ctl_q.fz    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        dat_q <= dat_d;
    end

    assign sys_rst        = (ctl_q.phase != PH_RUN);
    assign addr_low_hold  = (ctl_q.phase != PH_RUN);
    assign periph_clk_en  = (ctl_q.phase == PH_RUN);
    assign fetch_zero     = ctl_q.fz;
    assign boot_mode      = dat_q.boot;
    assign tristate_en    = dat_q.trist;
    assign strap_unstable = dat_q.unstable;
endmodule

// File: rtl/rst_strap_chk.sv
module rst_strap_chk #(
    parameter int WINDOW = 10
) (
    input logic       clk,
    input logic       rst_pin_n,
    input logic       sys_rst,
    input logic       addr_low_hold,
    input logic       periph_clk_en,
    input logic       fetch_zero,
    input logic [1:0] boot_mode,
    input logic       tristate_en,
    input logic       strap_unstable
);
    localparam int HW = $clog2(WINDOW + 2);
    localparam logic [HW-1:0] HMAX = HW'(WINDOW + 1);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n)
            hi_cnt <= '0;
        else if (!sys_rst)
            hi_cnt <= '0;
        else if (hi_cnt != HMAX)
            hi_cnt <= hi_cnt + 1'b1;
    end

    assert_hold_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_pin_n)
        sys_rst |-> (addr_low_hold && !periph_clk_en));

    assert_release_window_R2: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $fell(sys_rst) |-> (hi_cnt >= HW'(3) && hi_cnt <= HW'(WINDOW)));

    assert_modes_only_at_release_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !$stable({boot_mode, tristate_en, strap_unstable}) |-> $fell(sys_rst));

    assert_fetch_at_release_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
        fetch_zero |-> (!sys_rst && $past(sys_rst)));

    assert_fetch_single_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
        fetch_zero |=> !fetch_zero);
endmodule

bind rst_strap_ctrl rst_strap_chk #(.WINDOW(WINDOW)) u_chk (
    .clk            (clk),
    .rst_pin_n      (rst_pin_n),
    .sys_rst        (sys_rst),
    .addr_low_hold  (addr_low_hold),
    .periph_clk_en  (periph_clk_en),
    .fetch_zero     (fetch_zero),
    .boot_mode      (boot_mode),
    .tristate_en    (tristate_en),
    .strap_unstable (strap_unstable)
);

// File: tb/rst_strap_ctrl_tb.sv
`timescale 1ns/1ps
module rst_strap_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_pin_n = 1'b1;
    logic       wdt_req = 1'b0;
    logic       boot_sel_pin = 1'b0;
    logic       tri_n_pin = 1'b1;
    logic       has_nvm = 1'b0;
    logic       sys_rst, addr_low_hold, periph_clk_en, fetch_zero;
    logic [1:0] boot_mode;
    logic       tristate_en, strap_unstable;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    int exp_boot = 0;
    int exp_tri = 0;
    int exp_unst = 0;

    always #4 clk = ~clk;

    rst_strap_ctrl u_dut (
        .clk            (clk),
        .rst_pin_n      (rst_pin_n),
        .wdt_req        (wdt_req),
        .boot_sel_pin   (boot_sel_pin),
        .tri_n_pin      (tri_n_pin),
        .has_nvm        (has_nvm),
        .sys_rst        (sys_rst),
        .addr_low_hold  (addr_low_hold),
        .periph_clk_en  (periph_clk_en),
        .fetch_zero     (fetch_zero),
        .boot_mode      (boot_mode),
        .tristate_en    (tristate_en),
        .strap_unstable (strap_unstable)
    );

    function automatic int boot_of(input bit bs, input bit nvm);
        if (!bs) return 0;
        return nvm ? 2 : 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_modes(input string req);
        chk({req, " boot_mode R4"}, int'(boot_mode), exp_boot);
        chk({req, " tristate_en R5"}, int'(tristate_en), exp_tri);
        chk({req, " strap_unstable R6"}, int'(strap_unstable), exp_unst);
    endtask

    // Pin reset held low for L rising edges; optional strap flip after edge flip_e.
    task automatic pin_reset(input int L, input bit bs, input bit tn, input bit nvm,
                             input int flip_e, input bit with_wdt);
        int n;
        int exp_n;
        bit rel;
        @(negedge clk);
        boot_sel_pin = (flip_e > 0) ? ~bs : bs;
        tri_n_pin    = tn;
        has_nvm      = nvm;
        rst_pin_n    = 1'b0;
        wdt_req      = with_wdt;
        #1;
        chk("R1 sys_rst on pin fall", int'(sys_rst), 1);
        chk("R1 addr_low_hold", int'(addr_low_hold), 1);
        chk("R1 periph_clk_en", int'(periph_clk_en), 0);
        for (int k = 1; k <= L; k++) begin
            @(posedge clk);
            @(negedge clk);
            wdt_req = 1'b0;
            if (k == flip_e) boot_sel_pin = bs;
        end
        rst_pin_n = 1'b1;
        n   = L;
        rel = 1'b0;
        while (!rel && n < L + 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!sys_rst) rel = 1'b1;
            else if (periph_clk_en) chk("R1 clocks off in reset", 1, 0);
        end
        exp_n = (L + 3 > 10) ? L + 3 : 10;
        if (L + 3 > 10) chk("R2 release edge", n, exp_n);
        else            chk("R3 release edge (short pulse)", n, exp_n);
        chk("R9 fetch_zero at release", int'(fetch_zero), 1);
        exp_boot = boot_of(bs, nvm);
        exp_tri  = tn ? 0 : 1;
        exp_unst = (flip_e > 0 && flip_e >= n - 9) ? 1 : 0;
        check_modes(with_wdt ? "R8 pin+wdt" : "pin reset");
        @(negedge clk);
        chk("R9 fetch_zero one cycle", int'(fetch_zero), 0);
    endtask

    task automatic wdt_reset(input bit bs, input bit tn, input bit nvm);
        int hi;
        @(negedge clk);
        wdt_req      = 1'b1;
        boot_sel_pin = bs;
        tri_n_pin    = tn;
        has_nvm      = nvm;
        @(posedge clk);
        @(negedge clk);
        wdt_req = 1'b0;
        hi = 0;
        while (sys_rst && hi < 40) begin
            hi++;
            if (!addr_low_hold) chk("R1 addr hold in wdt reset", 0, 1);
            @(posedge clk);
            @(negedge clk);
        end
        chk("R7 watchdog reset length", hi, 10);
        chk("R9 fetch_zero after wdt", int'(fetch_zero), 1);
        check_modes("R7 no resample on wdt");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1 rst_pin_n = 1'b0;
        #1;
        chk("R1 reset state sys_rst", int'(sys_rst), 1);
        chk("R1 reset state addr_low_hold", int'(addr_low_hold), 1);
        chk("R1 reset state periph_clk_en", int'(periph_clk_en), 0);
        chk("R9 reset state fetch_zero", int'(fetch_zero), 0);

        pin_reset(12, 1'b1, 1'b1, 1'b1, 0, 1'b0);
        pin_reset(3,  1'b0, 1'b0, 1'b1, 0, 1'b0);
        pin_reset(1,  1'b1, 1'b1, 1'b0, 0, 1'b0);
        pin_reset(7,  1'b1, 1'b0, 1'b0, 0, 1'b0);
        pin_reset(8,  1'b0, 1'b1, 1'b0, 0, 1'b0);
        pin_reset(20, 1'b1, 1'b1, 1'b1, 16, 1'b0);
        wdt_reset(1'b0, 1'b0, 1'b0);
        pin_reset(20, 1'b0, 1'b1, 1'b1, 14, 1'b0);
        pin_reset(20, 1'b1, 1'b0, 1'b1, 13, 1'b0);
        pin_reset(20, 1'b1, 1'b1, 1'b0, 5, 1'b0);
        wdt_reset(1'b0, 1'b0, 1'b1);
        pin_reset(15, 1'b0, 1'b0, 1'b0, 0, 1'b1);

        @(negedge clk);
        wdt_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wdt_req = 1'b0;
        repeat (4) @(posedge clk);
        pin_reset(4, 1'b1, 1'b1, 1'b1, 0, 1'b0);

        for (int it = 0; it < 60; it++) begin
            int sel;
            int L;
            int fe;
            sel = int'($urandom_range(0, 3));
            if (sel == 0) begin
                wdt_reset(1'($urandom), 1'($urandom), 1'($urandom));
            end else begin
                L  = int'($urandom_range(1, 25));
                fe = (L > 1 && $urandom_range(0, 2) == 0) ? int'($urandom_range(1, L)) : 0;
                pin_reset(L, 1'($urandom), 1'($urandom), 1'($urandom), fe,
                          1'($urandom_range(0, 4) == 0));
            end
            repeat (int'($urandom_range(0, 3))) @(negedge clk);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule